// File: doc/BRIEF.md
# Credit-Based Slot Bus Arbiter

This block decides, for every slot of a 14-port time-division bus, which port may transmit in the next slot. Each port presents a request, a flag that says whether it is sending a command or a response, a destination port number, an interlock (MODIFY) line, a BURST line, a buffer-freed pulse, and a flag that says whether it has room for a response. The arbiter holds one free-command-buffer credit counter per port. A command is only granted toward a destination that still has credit. A response is only granted toward a destination that reports response room.

Grants are combinational within the slot in which the decision is made, and at most one port is granted. The winner transmits in the following slot. Ports 4 and up win by fixed priority, with the highest number winning. Ports 0 to 3 form a low-priority group that shares access by rotation.

A port that is granted while asserting MODIFY starts an interlocked sequence, shown on the lock output. While the lock is held, only that port may win among MODIFY requesters; other ports are unaffected. A BURST assertion by the current response holder suppresses the grant of that slot, so the holder keeps the bus. The holder can keep it for at most four slots in a row.

Top module: `slot_arbiter`

## Requirements
- R1: A command request (is_rsp_i low) is eligible only while the credit counter of its destination is nonzero; rdy_o[d] is high exactly when port d's counter is nonzero.
- R2: A response request (is_rsp_i high) is eligible only while rsp_space_i of its destination is high, and granting it leaves every credit counter unchanged.
- R3: Among eligible ports numbered 4 to 13, the highest number is granted. Ports 0 to 3 are granted only when none of ports 4 to 13 is eligible.
- R4: Within ports 0 to 3, the search starts at the member after the last granted member and wraps from 3 to 0. After reset the search starts at port 0.
- R5: grant_o has at most one bit set. It is a combinational function of the current inputs and the stored state, and it is valid in the slot in which it is decided.
- R6: A command grant decrements the destination's counter at the next edge. A buf_free_i pulse increments that port's own counter. When both happen together, the counter is unchanged. An increment at the all-ones value (7 for the 3-bit default) is dropped.
- R7: When any burst_i bit is high, grant_o is zero in that slot, for up to three consecutive burst slots. On the fourth consecutive burst slot, BURST is ignored and a normal decision is made. The run count restarts after any slot in which BURST is not honoured.
- R8: lock_o rises at the edge after a grant to a port whose modify_i is high, provided lock_o was low.
- R9: lock_o falls at the edge after the lock owner's modify_i is low.
- R10: While lock_o is high, a port other than the owner that asserts modify_i is not eligible. Ports without modify_i, and the owner, arbitrate normally.
- R11: A destination number of 14 or more makes a request ineligible, whether it is a command or a response.
- R12: After reset, lock_o is low, every counter holds its initial value (2 by default, so all rdy_o bits are high), and grant_o is zero when no port requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Slot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 14 | Per-port transmit request |
| is_rsp_i | input | 14 | Per-port request kind: 1 response, 0 command |
| dest_i | input | 56 | Per-port destination, 4 bits each, port p at bits [4p+3:4p] |
| modify_i | input | 14 | Per-port interlock request |
| burst_i | input | 14 | Burst hold from the port currently sending a response |
| buf_free_i | input | 14 | Per-port pulse: one command buffer of that port became free |
| rsp_space_i | input | 14 | Per-port flag: response room available |
| grant_o | output | 14 | One-hot-or-zero grant for the next slot |
| rdy_o | output | 14 | Per-port nonzero-credit flag |
| lock_o | output | 1 | Interlocked sequence in progress |

## Verification
The assertions assume that the inputs are stable around each clock edge and that only a port legitimately holding the bus drives burst_i. They do not assume that destinations are in range or that buffer-freed pulses are paced. The stimulus therefore changes inputs just after each rising edge. Besides the directed cases, it includes out-of-range destinations, freed pulses that run into saturation, and burst runs longer than four slots, so that these corners also appear in the random phase.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  typedef enum logic [1:0] {CR_HOLD, CR_INC, CR_DEC} cr_act_e;
  localparam int unsigned BURST_LIMIT_DEF = 4;
endpackage

// File: rtl/slot_arb_credit.sv
module slot_arb_credit import slot_arb_pkg::*; #(
  parameter int unsigned N_PORTS = 14,
  parameter int unsigned CRED_W  = 3,
  parameter logic [N_PORTS*CRED_W-1:0] INIT_CREDITS = {N_PORTS{CRED_W'(2)}}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PORTS-1:0] inc_i,
  input  logic [N_PORTS-1:0] dec_i,
  output logic [N_PORTS-1:0] rdy_o
);
  for (genvar g = 0; g < N_PORTS; g++) begin : g_cnt
    logic [CRED_W-1:0] cnt_q;
    cr_act_e act;
    always_comb begin
      if (inc_i[g] && !dec_i[g])      act = CR_INC;
      else if (dec_i[g] && !inc_i[g]) act = CR_DEC;
      else                            act = CR_HOLD;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= INIT_CREDITS[g*CRED_W +: CRED_W];
      else begin
        case (act)
          CR_INC:  if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
          CR_DEC:  if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          default: cnt_q <= cnt_q;
        endcase
      end
    end
    assign rdy_o[g] = |cnt_q;
  end
endmodule

// File: rtl/slot_arb_pick.sv
module slot_arb_pick #(
  parameter int unsigned N_PORTS = 14,
  parameter int unsigned GROUP_N = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PORTS-1:0] elig_i,
  input  logic               hold_i,
  output logic [N_PORTS-1:0] grant_o
);
  localparam int unsigned GW = (GROUP_N > 1) ? $clog2(GROUP_N) : 1;

  logic [GW-1:0]      ptr_q;
  logic [N_PORTS-1:0] win;
  logic               grp_hit;
  logic [GW-1:0]      grp_idx;

  always_comb begin
    logic found;
    win   = '0;
    found = 1'b0;
    for (int p = N_PORTS - 1; p >= int'(GROUP_N); p--) begin
      if (!found && elig_i[p]) begin
        win[p] = 1'b1;
        found  = 1'b1;
      end
    end
    for (int k = 1; k <= int'(GROUP_N); k++) begin
      int q;
      q = (int'(ptr_q) + k) % int'(GROUP_N);
      if (!found && elig_i[q]) begin
        win[q] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  assign grant_o = hold_i ? '0 : win;

  always_comb begin
    grp_hit = 1'b0;
    grp_idx = '0;
    for (int g = 0; g < int'(GROUP_N); g++) begin
      if (grant_o[g]) begin
        grp_hit = 1'b1;
        grp_idx = GW'(g);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= GW'(GROUP_N - 1);
    else if (grp_hit) ptr_q <= grp_idx;
  end
endmodule

// File: rtl/slot_arb_lock.sv
module slot_arb_lock #(
  parameter int unsigned N_PORTS = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PORTS-1:0] grant_i,
  input  logic [N_PORTS-1:0] modify_i,
  output logic [N_PORTS-1:0] mask_o,
  output logic               lock_o
);
  logic               lock_q;
  logic [N_PORTS-1:0] own_q;
  logic               start, stop;

  assign start  = !lock_q && |(grant_i & modify_i);
  assign stop   = lock_q && !(|(modify_i & own_q));
  assign mask_o = lock_q ? (modify_i & ~own_q) : '0;
  assign lock_o = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      own_q  <= '0;
    end else if (stop) begin
      lock_q <= 1'b0;
      own_q  <= '0;
    end else if (start) begin
      lock_q <= 1'b1;
      own_q  <= grant_i;
    end
  end
endmodule

// File: rtl/slot_arb_burst.sv
module slot_arb_burst #(
  parameter int unsigned MAX_BURST = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic burst_any_i,
  output logic hold_o
);
  localparam int unsigned RW = $clog2(MAX_BURST + 1);
  logic [RW-1:0] run_q;

  // at most MAX_BURST-1 slots may be held past the granted one
  assign hold_o = burst_any_i && (run_q < RW'(MAX_BURST - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (hold_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter #(
  parameter int unsigned N_PORTS   = 14,
  parameter int unsigned GROUP_N   = 4,
  parameter int unsigned MAX_BURST = slot_arb_pkg::BURST_LIMIT_DEF,
  parameter int unsigned CRED_W    = 3,
  parameter logic [N_PORTS*CRED_W-1:0] INIT_CREDITS = {N_PORTS{CRED_W'(2)}},
  localparam int unsigned PW = $clog2(N_PORTS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_PORTS-1:0]    req_i,
  input  logic [N_PORTS-1:0]    is_rsp_i,
  input  logic [N_PORTS*PW-1:0] dest_i,
  input  logic [N_PORTS-1:0]    modify_i,
  input  logic [N_PORTS-1:0]    burst_i,
  input  logic [N_PORTS-1:0]    buf_free_i,
  input  logic [N_PORTS-1:0]    rsp_space_i,
  output logic [N_PORTS-1:0]    grant_o,
  output logic [N_PORTS-1:0]    rdy_o,
  output logic                  lock_o
);
  logic [N_PORTS-1:0] rdy, elig, dec, lock_mask;
  logic               hold;

  always_comb begin
    for (int p = 0; p < int'(N_PORTS); p++) begin
      logic [PW-1:0] dst;
      logic cmd_ok, rsp_ok;
      dst    = dest_i[p*PW +: PW];
      cmd_ok = 1'b0;
      rsp_ok = 1'b0;
      // out-of-range destinations match nothing
      for (int d = 0; d < int'(N_PORTS); d++) begin
        if (dst == PW'(d)) begin
          cmd_ok = rdy[d];
          rsp_ok = rsp_space_i[d];
        end
      end
      elig[p] = req_i[p] && !lock_mask[p] && (is_rsp_i[p] ? rsp_ok : cmd_ok);
    end
  end

  always_comb begin
    dec = '0;
    for (int d = 0; d < int'(N_PORTS); d++) begin
      for (int p = 0; p < int'(N_PORTS); p++) begin
        if (grant_o[p] && !is_rsp_i[p] && dest_i[p*PW +: PW] == PW'(d)) dec[d] = 1'b1;
      end
    end
  end

  slot_arb_credit #(
    .N_PORTS(N_PORTS), .CRED_W(CRED_W), .INIT_CREDITS(INIT_CREDITS)
  ) u_credit (
    .clk_i, .rst_ni, .inc_i(buf_free_i), .dec_i(dec), .rdy_o(rdy)
  );

  slot_arb_burst #(.MAX_BURST(MAX_BURST)) u_burst (
    .clk_i, .rst_ni, .burst_any_i(|burst_i), .hold_o(hold)
  );

  slot_arb_lock #(.N_PORTS(N_PORTS)) u_lock (
    .clk_i, .rst_ni, .grant_i(grant_o), .modify_i, .mask_o(lock_mask), .lock_o
  );

  slot_arb_pick #(.N_PORTS(N_PORTS), .GROUP_N(GROUP_N)) u_pick (
    .clk_i, .rst_ni, .elig_i(elig), .hold_i(hold), .grant_o
  );

  assign rdy_o = rdy;
endmodule

// File: rtl/slot_arbiter_chk.sv
module slot_arbiter_chk #(
  parameter int unsigned N_PORTS   = 14,
  parameter int unsigned MAX_BURST = 4,
  localparam int unsigned PW = $clog2(N_PORTS)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [N_PORTS-1:0]    is_rsp_i,
  input logic [N_PORTS*PW-1:0] dest_i,
  input logic [N_PORTS-1:0]    modify_i,
  input logic [N_PORTS-1:0]    burst_i,
  input logic [N_PORTS-1:0]    rsp_space_i,
  input logic [N_PORTS-1:0]    grant_o,
  input logic [N_PORTS-1:0]    rdy_o,
  input logic                  lock_o
);
  function automatic logic sel(logic [N_PORTS-1:0] v, logic [PW-1:0] d);
    logic r;
    r = 1'b0;
    for (int i = 0; i < int'(N_PORTS); i++) if (d == PW'(i)) r = v[i];
    return r;
  endfunction

  int unsigned        brun;
  logic [N_PORTS-1:0] own_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brun  <= 0;
      own_q <= '0;
    end else begin
      brun <= ((|burst_i) && brun < MAX_BURST - 1) ? brun + 1 : 0;
      if (!lock_o && |(grant_o & modify_i)) own_q <= grant_o;
    end
  end

  p_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  p_burst_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|burst_i) && brun < MAX_BURST - 1) |-> grant_o == '0);

  p_lock_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_o && |(grant_o & modify_i)) |=> lock_o);

  p_lock_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !(|(modify_i & own_q))) |=> !lock_o);

  p_lock_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> (grant_o & modify_i & ~own_q) == '0);

  for (genvar i = 0; i < N_PORTS; i++) begin : g_port
    p_cmd_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o[i] && !is_rsp_i[i]) |-> sel(rdy_o, dest_i[i*PW +: PW]));
    p_rsp_space_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o[i] && is_rsp_i[i]) |-> sel(rsp_space_i, dest_i[i*PW +: PW]));
  end
endmodule

bind slot_arbiter slot_arbiter_chk #(.N_PORTS(N_PORTS), .MAX_BURST(MAX_BURST)) u_chk (.*);

// File: tb/tb_slot_arbiter.sv
module tb_slot_arbiter;
  localparam int  N  = 14;
  localparam int  PW = 4;
  localparam int  G  = 4;
  localparam int  MB = 4;
  localparam int  CMAX = 7;
  localparam time CLK_PERIOD = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0]    req_i, is_rsp_i, modify_i, burst_i, buf_free_i, rsp_space_i;
  logic [N*PW-1:0] dest_i;
  logic [N-1:0]    grant_o, rdy_o;
  logic            lock_o;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  slot_arbiter dut (.*);

  int checks = 0, fails = 0;
  string tag = "R12";
  bit done = 0;

  // reference model state
  int cred[N];
  int rr, own, brun;
  bit lk;

  function automatic int dst(int p);
    return int'(dest_i[p*PW +: PW]);
  endfunction

  function automatic bit elig(int p);
    int d;
    d = dst(p);
    if (!req_i[p] || d >= N) return 0;
    if (lk && modify_i[p] && p != own) return 0;
    return is_rsp_i[p] ? rsp_space_i[d] : (cred[d] > 0);
  endfunction

  function automatic int pick();
    if ((|burst_i) && brun < MB - 1) return -1;
    for (int p = N - 1; p >= G; p--) if (elig(p)) return p;
    for (int k = 1; k <= G; k++) if (elig((rr + k) % G)) return (rr + k) % G;
    return -1;
  endfunction

  task automatic model_reset();
    for (int d = 0; d < N; d++) cred[d] = 2;
    rr = G - 1; own = -1; brun = 0; lk = 0;
  endtask

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic cycle();
    int w;
    logic [N-1:0] eg, er;
    @(negedge clk_i);
    w  = pick();
    eg = (w >= 0) ? (N'(1) << w) : '0;
    er = '0;
    for (int d = 0; d < N; d++) er[d] = cred[d] > 0;
    check(grant_o == eg, "grant", int'(grant_o), int'(eg));
    check(lock_o == lk, "lock", int'(lock_o), int'(lk));
    check(rdy_o == er, "rdy", int'(rdy_o), int'(er));
    for (int d = 0; d < N; d++) begin
      bit dc;
      dc = (w >= 0) && !is_rsp_i[w] && dst(w) == d;
      if (buf_free_i[d] && !dc && cred[d] < CMAX) cred[d]++;
      else if (dc && !buf_free_i[d]) cred[d]--;
    end
    if (w >= 0 && w < G) rr = w;
    if (lk) begin
      if (!modify_i[own]) begin lk = 0; own = -1; end
    end else if (w >= 0 && modify_i[w]) begin
      lk = 1; own = w;
    end
    brun = ((|burst_i) && brun < MB - 1) ? brun + 1 : 0;
    @(posedge clk_i);
    #1;
  endtask

  task automatic clr();
    req_i = '0; is_rsp_i = '0; modify_i = '0; burst_i = '0;
    buf_free_i = '0; rsp_space_i = '0; dest_i = '0;
  endtask

  task automatic put(int p, bit rsp, int d, bit mod);
    req_i[p] = 1'b1; is_rsp_i[p] = rsp; modify_i[p] = mod;
    dest_i[p*PW +: PW] = PW'(d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clr();
    model_reset();
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R12: reset state
    tag = "R12"; cycle();
    // R3: fixed priority among high ports; dest 10 runs out after two grants
    tag = "R3"; put(13, 0, 10, 0); put(9, 0, 10, 0); put(5, 0, 10, 0);
    repeat (3) cycle();
    clr();
    // R1: credit exhaustion at dest 6
    tag = "R1"; put(8, 0, 6, 0);
    repeat (3) cycle();
    // R6: saturation then simultaneous dec/inc, then drain
    tag = "R6"; clr(); buf_free_i[6] = 1'b1;
    repeat (10) cycle();
    put(8, 0, 6, 0);
    repeat (2) cycle();
    buf_free_i[6] = 1'b0;
    repeat (9) cycle();
    // R2: response needs room, consumes no credit
    tag = "R2"; clr(); put(7, 1, 6, 0);
    cycle();
    rsp_space_i[6] = 1'b1;
    repeat (2) cycle();
    // R4: rotation in low group
    tag = "R4"; clr(); buf_free_i[12] = 1'b1;
    for (int p = 0; p < G; p++) put(p, 0, 12, 0);
    repeat (6) cycle();
    req_i[1] = 1'b0; req_i[2] = 1'b0;
    repeat (3) cycle();
    // R7: burst run longer than the limit
    tag = "R7"; clr(); buf_free_i[12] = 1'b1; put(4, 0, 12, 0); burst_i[1] = 1'b1;
    repeat (6) cycle();
    burst_i = '0;
    cycle();
    // R8, R9, R10: interlock
    tag = "R8"; clr(); buf_free_i[12] = 1'b1; put(10, 0, 12, 1);
    cycle();
    tag = "R10"; req_i[10] = 1'b0; put(11, 0, 12, 1); put(2, 0, 12, 0);
    repeat (2) cycle();
    tag = "R9"; modify_i[10] = 1'b0;
    repeat (3) cycle();
    // R11: out-of-range destination
    tag = "R11"; clr(); rsp_space_i = '1; put(9, 0, 15, 0); put(12, 1, 14, 0);
    repeat (2) cycle();
    // mixed random traffic, tagged R5
    tag = "R5";
    for (int i = 0; i < 800; i++) begin
      req_i       = N'($urandom);
      is_rsp_i    = N'($urandom);
      modify_i    = N'($urandom) & N'($urandom);
      rsp_space_i = N'($urandom);
      buf_free_i  = N'($urandom) & N'($urandom);
      burst_i     = ($urandom % 4 == 0) ? N'(1) << ($urandom % N) : '0;
      for (int p = 0; p < N; p++) dest_i[p*PW +: PW] = PW'($urandom);
      cycle();
    end
    finish_run();
  end
endmodule